// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block sequences a small CPU core into and out of its two low-power states. A decoded stop strobe parks the core in a deep sleep where every clock, the crystal oscillator included, is gated off. A decoded wait strobe first asks the microcode to stack the registers and then idles the core with the oscillator running. While it waits, the block keeps the bus busy with read cycles to the location that holds the stacked condition code.

The way the core leaves sleep depends on which request line fired and on the condition-code mask bits. There are three outcomes: resume at the next instruction, start exception stacking, or enter service of a wait that was already stacked. Each outcome is issued as a single-cycle pulse, and the core is back in the running state on the following cycle. The block also holds off interrupt recognition for one instruction after any instruction that writes the mask bits. It gives the CPU a flag for this and applies the same hold to its own wake decisions. A reset in any state returns the block to running and raises the reset-sequence request.

Top module: `lpw_ctrl`

## Requirements
- R1: While reset (rst_n low, sampled at a clock edge) is applied, osc_en_o, per_clk_en_o and tmr_clk_en_o are 1. resume_o, stack_start_o, svc_o, bus_rd_o and int_inhibit_o are 0, and rst_seq_o is 1. rst_seq_o returns to 0 after the first edge that samples rst_n high.
- R2: A stop strobe taken in the running state with ccr_s_i=0 drives osc_en_o, per_clk_en_o and tmr_clk_en_o to 0 from the next cycle on.
- R3: A stop strobe with ccr_s_i=1 has no effect. The clock enables stay 1 and no pulse is issued.
- R4: In stop, irq_ext_i or irq_int_i wakes the core only when ccr_i_i=0, and the wake outcome is a resume_o pulse. With ccr_i_i=1 these lines leave the core stopped.
- R5: In stop, xirq_i always wakes the core. The outcome is a stack_start_o pulse when ccr_x_i=0 and a resume_o pulse when ccr_x_i=1.
- R6: When several wake lines are active in the same cycle, xirq_i takes priority over irq_ext_i, and irq_ext_i takes priority over irq_int_i.
- R7: A wait strobe produces a one-cycle stack_start_o pulse on the next cycle. The block then enters the wait state, in which osc_en_o and per_clk_en_o stay 1.
- R8: In wait, a svc_o pulse is issued if xirq_i is active with ccr_x_i=0, or if irq_ext_i or irq_int_i is active with ccr_i_i=0. Any other combination leaves the core waiting.
- R9: In wait, tmr_clk_en_o is 0 exactly when ccr_i_i=1 and wdog_en_i=0.
- R10: In wait, bus_rd_o is 1 on every cycle. bus_addr_o holds the stack_addr_i value captured with the wait strobe, whatever stack_addr_i does afterwards.
- R11: After a completing instruction that writes the masks (instr_done_i and mask_wr_i both 1), int_inhibit_o is 1. It stays 1 until the next completion, which is instr_done_i, a stop strobe or a wait strobe. While int_inhibit_o is 1, no wake outcome is issued.
- R12: A reset during stop or wait returns the block to running with the clocks enabled, and rst_seq_o is raised.
- R13: Every wake outcome (resume_o, stack_start_o, svc_o) lasts exactly one cycle, at most one of them is high at a time, and the core is running on the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_exec_i | input | 1 | Decoded stop instruction strobe |
| wait_exec_i | input | 1 | Decoded wait instruction strobe |
| instr_done_i | input | 1 | An instruction completed this cycle |
| mask_wr_i | input | 1 | The completing instruction wrote the mask bits |
| ccr_s_i | input | 1 | Stop-disable bit of the condition code |
| ccr_i_i | input | 1 | Ordinary interrupt mask bit |
| ccr_x_i | input | 1 | Non-maskable-line mask bit |
| irq_int_i | input | 1 | Internal peripheral interrupt request |
| irq_ext_i | input | 1 | External interrupt request |
| xirq_i | input | 1 | High-priority external request |
| wdog_en_i | input | 1 | Watchdog enabled |
| stack_addr_i | input | ADDR_W | Address of the stacked condition code |
| osc_en_o | output | 1 | Crystal oscillator enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| tmr_clk_en_o | output | 1 | Free-running timer clock enable |
| resume_o | output | 1 | Resume at next instruction (pulse) |
| stack_start_o | output | 1 | Start register stacking (pulse) |
| svc_o | output | 1 | Begin service after a stacked wait (pulse) |
| rst_seq_o | output | 1 | Reset-sequence request |
| bus_rd_o | output | 1 | Idle bus read strobe |
| bus_addr_o | output | ADDR_W | Idle bus read address |
| int_inhibit_o | output | 1 | Interrupt recognition held off |

## Verification
The assertions watch, on every cycle, the properties that are local in time. They check that outcome pulses stay exclusive and last one cycle, and that the gating follows a taken stop or wait strobe. They also check that the idle address stays steady, that the timer gate obeys the mask and watchdog rule while waiting, and that no resume or service appears while recognition is held off. The decision table itself can only be shown by the bench's scenarios. That table covers which outcome each mix of request lines and mask bits produces, including the priority among lines, the stop no-op and the recovery by reset.

// File: rtl/lpw_pkg.sv
// Shared types for the low-power wake-up controller.
// Assumes: state and action codes are only compared, never decoded by bit.
package lpw_pkg;
    typedef enum logic [2:0] {
        LPW_RUN,
        LPW_WAIT_STACK,
        LPW_WAIT,
        LPW_STOP,
        LPW_WAKE
    } lpw_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RESUME,
        ACT_STACK,
        ACT_SVC
    } lpw_act_e;
endpackage

// File: rtl/lpw_mask_guard.sv
// Counts completed instructions after a mask write and flags the window in
// which interrupt recognition must be held off.
// Assumes: step_i marks every instruction completion, mask_step_i is a
// completion that also wrote the masks (it implies step_i).
module lpw_mask_guard #(
    parameter int HOLD_INSTRS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic mask_step_i,
    output logic inhibit_o
);
    localparam int CW = $clog2(HOLD_INSTRS + 1);

    logic [CW-1:0] left_q;

    // Reload on a mask write, count down on every other completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (mask_step_i) begin
            left_q <= CW'(HOLD_INSTRS);
        end else if (step_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Hold-off is active while instructions remain in the window.
    always_comb inhibit_o = (left_q != '0);
endmodule

// File: rtl/lpw_wake_arb.sv
// Decides the wake outcome from the request lines and mask bits.
// Assumes: in_stop_i and in_wait_i are never both high.
// Priority: high-priority line, then external, then internal request.
module lpw_wake_arb
    import lpw_pkg::*;
(
    input  logic     in_stop_i,
    input  logic     in_wait_i,
    input  logic     inhibit_i,
    input  logic     mask_i_i,
    input  logic     mask_x_i,
    input  logic     xirq_i,
    input  logic     irq_ext_i,
    input  logic     irq_int_i,
    output lpw_act_e act_o
);
    logic ord_req;

    // Ordinary lines are merged; both share the same mask bit.
    always_comb ord_req = irq_ext_i | irq_int_i;

    // Pick the outcome for the present sleep state.
    always_comb begin
        act_o = ACT_NONE;
        if (!inhibit_i) begin
            if (in_stop_i) begin
                if (xirq_i) begin
                    act_o = mask_x_i ? ACT_RESUME : ACT_STACK;
                end else if (ord_req && !mask_i_i) begin
                    act_o = ACT_RESUME;
                end
            end else if (in_wait_i) begin
                if (xirq_i && !mask_x_i) begin
                    act_o = ACT_SVC;
                end else if (ord_req && !mask_i_i) begin
                    act_o = ACT_SVC;
                end
            end
        end
    end
endmodule

// File: rtl/lpw_clk_gate.sv
// Derives the oscillator, peripheral and timer clock enables.
// Assumes: peripheral-local gating during wait is done elsewhere.
module lpw_clk_gate
    import lpw_pkg::*;
(
    input  lpw_state_e state_i,
    input  logic       mask_i_i,
    input  logic       wdog_en_i,
    output logic       osc_en_o,
    output logic       per_clk_en_o,
    output logic       tmr_clk_en_o
);
    logic stopped;
    logic tmr_idle;

    // Deep sleep shuts every clock.
    always_comb stopped = (state_i == LPW_STOP);

    // Timer may idle in wait only if masked and no watchdog needs it.
    always_comb tmr_idle = (state_i == LPW_WAIT) && mask_i_i && !wdog_en_i;

    // Drive the enables.
    always_comb begin
        osc_en_o     = !stopped;
        per_clk_en_o = !stopped;
        tmr_clk_en_o = !stopped && !tmr_idle;
    end
endmodule

// File: rtl/lpw_ctrl.sv
// Low-power wake-up controller top: state machine, idle-read address latch,
// outcome pulses and reset-sequence request.
// Assumes: stop and wait strobes are single-cycle and mutually exclusive
// (stop wins if both arrive); synchronous active-low reset.
module lpw_ctrl
    import lpw_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int HOLD_INSTRS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_exec_i,
    input  logic              wait_exec_i,
    input  logic              instr_done_i,
    input  logic              mask_wr_i,
    input  logic              ccr_s_i,
    input  logic              ccr_i_i,
    input  logic              ccr_x_i,
    input  logic              irq_int_i,
    input  logic              irq_ext_i,
    input  logic              xirq_i,
    input  logic              wdog_en_i,
    input  logic [ADDR_W-1:0] stack_addr_i,
    output logic              osc_en_o,
    output logic              per_clk_en_o,
    output logic              tmr_clk_en_o,
    output logic              resume_o,
    output logic              stack_start_o,
    output logic              svc_o,
    output logic              rst_seq_o,
    output logic              bus_rd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              int_inhibit_o
);
    lpw_state_e        state_q, state_d;
    lpw_act_e          act_q, arb_act;
    logic [ADDR_W-1:0] addr_q;
    logic              rst_seq_q;
    logic              run_stop, run_wait;
    logic              step, mask_step;

    // Strobes only count in the running state.
    always_comb begin
        run_stop = (state_q == LPW_RUN) && stop_exec_i;
        run_wait = (state_q == LPW_RUN) && wait_exec_i && !stop_exec_i;
    end

    // Every completed instruction, including stop and wait, advances the window.
    always_comb begin
        mask_step = instr_done_i && mask_wr_i;
        step      = instr_done_i || run_stop || run_wait;
    end

    lpw_mask_guard #(
        .HOLD_INSTRS (HOLD_INSTRS)
    ) guard_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .mask_step_i (mask_step),
        .inhibit_o   (int_inhibit_o)
    );

    lpw_wake_arb arb_i (
        .in_stop_i (state_q == LPW_STOP),
        .in_wait_i (state_q == LPW_WAIT),
        .inhibit_i (int_inhibit_o),
        .mask_i_i  (ccr_i_i),
        .mask_x_i  (ccr_x_i),
        .xirq_i    (xirq_i),
        .irq_ext_i (irq_ext_i),
        .irq_int_i (irq_int_i),
        .act_o     (arb_act)
    );

    lpw_clk_gate gate_i (
        .state_i      (state_q),
        .mask_i_i     (ccr_i_i),
        .wdog_en_i    (wdog_en_i),
        .osc_en_o     (osc_en_o),
        .per_clk_en_o (per_clk_en_o),
        .tmr_clk_en_o (tmr_clk_en_o)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LPW_RUN: begin
                if (run_stop && !ccr_s_i) begin
                    state_d = LPW_STOP;
                end else if (run_wait) begin
                    state_d = LPW_WAIT_STACK;
                end
            end
            LPW_WAIT_STACK: state_d = LPW_WAIT;
            LPW_WAIT, LPW_STOP: begin
                if (arb_act != ACT_NONE) begin
                    state_d = LPW_WAKE;
                end
            end
            LPW_WAKE: state_d = LPW_RUN;
            default:  state_d = LPW_RUN;
        endcase
    end

    // State, wake outcome and reset-request registers.
    always_ff @(posedge clk) begin
        rst_seq_q <= !rst_n;
        if (!rst_n) begin
            state_q <= LPW_RUN;
            act_q   <= ACT_NONE;
        end else begin
            state_q <= state_d;
            if (state_d == LPW_WAKE) begin
                act_q <= arb_act;
            end
        end
    end

    // Capture the stacked-code address with the wait strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (run_wait) begin
            addr_q <= stack_addr_i;
        end
    end

    // Outcome pulses and idle bus reads.
    always_comb begin
        resume_o      = (state_q == LPW_WAKE) && (act_q == ACT_RESUME);
        svc_o         = (state_q == LPW_WAKE) && (act_q == ACT_SVC);
        stack_start_o = (state_q == LPW_WAIT_STACK) ||
                        ((state_q == LPW_WAKE) && (act_q == ACT_STACK));
        bus_rd_o      = (state_q == LPW_WAIT);
        bus_addr_o    = addr_q;
        rst_seq_o     = rst_seq_q;
    end
endmodule

// File: rtl/lpw_ctrl_chk.sv
// Temporal checks for lpw_ctrl, attached by bind.
// Assumes: state_i is the top's registered state.
module lpw_ctrl_chk
    import lpw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input lpw_state_e        state_i,
    input logic              stop_exec_i,
    input logic              wait_exec_i,
    input logic              ccr_s_i,
    input logic              ccr_i_i,
    input logic              wdog_en_i,
    input logic              osc_en_o,
    input logic              per_clk_en_o,
    input logic              tmr_clk_en_o,
    input logic              resume_o,
    input logic              stack_start_o,
    input logic              svc_o,
    input logic              bus_rd_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              int_inhibit_o
);
    // R2
    stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == LPW_RUN && stop_exec_i && !ccr_s_i)
        |=> (!osc_en_o && !per_clk_en_o && !tmr_clk_en_o));

    // R3
    stop_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == LPW_RUN && stop_exec_i && ccr_s_i)
        |=> (osc_en_o && !resume_o && !stack_start_o && !svc_o));

    // R7
    wait_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == LPW_RUN && wait_exec_i && !stop_exec_i)
        |=> (stack_start_o && osc_en_o && per_clk_en_o));

    // R9
    wait_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && ccr_i_i && !wdog_en_i) |-> !tmr_clk_en_o);

    // R10
    idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && $past(bus_rd_o)) |-> $stable(bus_addr_o));

    // R11
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_inhibit_o |=> (!resume_o && !svc_o));

    // R13
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_o, stack_start_o, svc_o}));

    // R13
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o || svc_o) |=> (!resume_o && !svc_o && !stack_start_o && osc_en_o));
endmodule

bind lpw_ctrl lpw_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_i       (state_q),
    .stop_exec_i   (stop_exec_i),
    .wait_exec_i   (wait_exec_i),
    .ccr_s_i       (ccr_s_i),
    .ccr_i_i       (ccr_i_i),
    .wdog_en_i     (wdog_en_i),
    .osc_en_o      (osc_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .tmr_clk_en_o  (tmr_clk_en_o),
    .resume_o      (resume_o),
    .stack_start_o (stack_start_o),
    .svc_o         (svc_o),
    .bus_rd_o      (bus_rd_o),
    .bus_addr_o    (bus_addr_o),
    .int_inhibit_o (int_inhibit_o)
);

// File: tb/lpw_ctrl_tb_top.sv
// Sweeps every combination of mask bits and request lines through stop and
// wait, computing the expected outcome from the requirement rules.
module lpw_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        stop_exec_i, wait_exec_i, instr_done_i, mask_wr_i;
    logic        ccr_s_i, ccr_i_i, ccr_x_i;
    logic        irq_int_i, irq_ext_i, xirq_i, wdog_en_i;
    logic [15:0] stack_addr_i;
    logic        osc_en_o, per_clk_en_o, tmr_clk_en_o;
    logic        resume_o, stack_start_o, svc_o, rst_seq_o, bus_rd_o, int_inhibit_o;
    logic [15:0] bus_addr_o;

    int comps = 0;
    int errs  = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lpw_ctrl #(.ADDR_W(16), .HOLD_INSTRS(1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .stop_exec_i(stop_exec_i), .wait_exec_i(wait_exec_i),
        .instr_done_i(instr_done_i), .mask_wr_i(mask_wr_i),
        .ccr_s_i(ccr_s_i), .ccr_i_i(ccr_i_i), .ccr_x_i(ccr_x_i),
        .irq_int_i(irq_int_i), .irq_ext_i(irq_ext_i), .xirq_i(xirq_i),
        .wdog_en_i(wdog_en_i), .stack_addr_i(stack_addr_i),
        .osc_en_o(osc_en_o), .per_clk_en_o(per_clk_en_o), .tmr_clk_en_o(tmr_clk_en_o),
        .resume_o(resume_o), .stack_start_o(stack_start_o), .svc_o(svc_o),
        .rst_seq_o(rst_seq_o), .bus_rd_o(bus_rd_o), .bus_addr_o(bus_addr_o),
        .int_inhibit_o(int_inhibit_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] exp);
        comps++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic pulses_clear(input string req);
        cmp(req, {29'd0, resume_o, stack_start_o, svc_o}, 32'd0);
    endtask

    // R12: reset from a sleep state
    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        cmp("R12 rst_seq", rst_seq_o, 1);
        cmp("R12 clocks", {osc_en_o, per_clk_en_o, tmr_clk_en_o}, 3'b111);
        cmp("R12 bus_rd", bus_rd_o, 0);
        rst_n = 1'b1;
        tick();
        cmp("R12 rst_seq release", rst_seq_o, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", comps, errs);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        {stop_exec_i, wait_exec_i, instr_done_i, mask_wr_i} = '0;
        {ccr_s_i, ccr_i_i, ccr_x_i, irq_int_i, irq_ext_i, xirq_i, wdog_en_i} = '0;
        stack_addr_i = 16'h0;
        tick();
        tick();
        // R1
        cmp("R1 clocks", {osc_en_o, per_clk_en_o, tmr_clk_en_o}, 3'b111);
        pulses_clear("R1 pulses");
        cmp("R1 rst_seq", rst_seq_o, 1);
        cmp("R1 bus_rd/inhibit", {bus_rd_o, int_inhibit_o}, 2'b00);
        rst_n = 1'b1;
        tick();
        cmp("R1 rst_seq after release", rst_seq_o, 0);

        // R11: hold-off window through ordinary completions
        instr_done_i = 1'b1; mask_wr_i = 1'b1;
        tick();
        instr_done_i = 1'b0; mask_wr_i = 1'b0;
        cmp("R11 inhibit set", int_inhibit_o, 1);
        tick();
        cmp("R11 inhibit held without completion", int_inhibit_o, 1);
        instr_done_i = 1'b1;
        tick();
        instr_done_i = 1'b0;
        cmp("R11 inhibit cleared", int_inhibit_o, 0);
        // R11: a stop strobe (no-op here) also ends the window
        instr_done_i = 1'b1; mask_wr_i = 1'b1;
        tick();
        instr_done_i = 1'b0; mask_wr_i = 1'b0;
        ccr_s_i = 1'b1; stop_exec_i = 1'b1;
        tick();
        stop_exec_i = 1'b0; ccr_s_i = 1'b0;
        cmp("R11 stop ends window", int_inhibit_o, 0);

        // Stop sweep: S, I, X and the three request lines
        for (int k = 0; k < 64; k++) begin
            logic s, mi, mx, xq, eq, nq;
            logic [1:0] exp_act; // 0 none, 1 resume, 2 stack
            {s, mi, mx, xq, eq, nq} = 6'(k);
            ccr_s_i = s; ccr_i_i = mi; ccr_x_i = mx;
            stop_exec_i = 1'b1;
            tick();
            stop_exec_i = 1'b0;
            if (s) begin
                // R3
                cmp("R3 clocks on", {osc_en_o, per_clk_en_o, tmr_clk_en_o}, 3'b111);
                pulses_clear("R3 no pulse");
            end else begin
                // R2
                cmp("R2 clocks off", {osc_en_o, per_clk_en_o, tmr_clk_en_o}, 3'b000);
                // R4 R5 R6: priority xirq > external > internal
                if (xq)            exp_act = mx ? 2'd1 : 2'd2;
                else if ((eq || nq) && !mi) exp_act = 2'd1;
                else               exp_act = 2'd0;
                xirq_i = xq; irq_ext_i = eq; irq_int_i = nq;
                tick();
                xirq_i = 1'b0; irq_ext_i = 1'b0; irq_int_i = 1'b0;
                cmp("R4/R5/R6 resume", resume_o, exp_act == 2'd1);
                cmp("R5/R6 stack", stack_start_o, exp_act == 2'd2);
                cmp("R4 svc idle", svc_o, 0);
                if (exp_act != 2'd0) begin
                    tick();
                    // R13
                    pulses_clear("R13 single pulse");
                    cmp("R13 running", osc_en_o, 1);
                end else begin
                    cmp("R4 still stopped", osc_en_o, 0);
                    do_reset();
                end
            end
        end
        ccr_s_i = 1'b0;

        // Wait sweep: I, X, watchdog and the three request lines
        for (int k = 0; k < 64; k++) begin
            logic mi, mx, wd, xq, eq, nq, exp_svc;
            logic [15:0] a;
            {mi, mx, wd, xq, eq, nq} = 6'(k);
            a = 16'(16'h2000 + k * 37);
            ccr_i_i = mi; ccr_x_i = mx; wdog_en_i = wd;
            stack_addr_i = a;
            wait_exec_i = 1'b1;
            tick();
            wait_exec_i = 1'b0;
            stack_addr_i = ~a;
            // R7
            cmp("R7 stack pulse", stack_start_o, 1);
            cmp("R7 no idle read yet", bus_rd_o, 0);
            tick();
            cmp("R7 pulse ends", stack_start_o, 0);
            cmp("R7 osc/per on", {osc_en_o, per_clk_en_o}, 2'b11);
            // R9
            cmp("R9 timer", tmr_clk_en_o, !(mi && !wd));
            // R10
            cmp("R10 bus_rd", bus_rd_o, 1);
            cmp("R10 addr", bus_addr_o, a);
            // R8
            exp_svc = (xq && !mx) || ((eq || nq) && !mi);
            xirq_i = xq; irq_ext_i = eq; irq_int_i = nq;
            tick();
            xirq_i = 1'b0; irq_ext_i = 1'b0; irq_int_i = 1'b0;
            cmp("R8 svc", svc_o, exp_svc);
            cmp("R8 no resume/stack", {resume_o, stack_start_o}, 2'b00);
            if (exp_svc) begin
                tick();
                // R13
                pulses_clear("R13 svc single");
                cmp("R13 left wait", bus_rd_o, 0);
            end else begin
                cmp("R8 still waiting", bus_rd_o, 1);
                cmp("R10 addr stable", bus_addr_o, a);
                do_reset();
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", comps, errs);
        $finish;
    end
endmodule